// File: doc/BRIEF.md
# Dual-Group Interrupt Status Controller

This block collects event pulses from two groups of sources and turns them into one latched interrupt line for a processor. The first group holds a single clock-error event. The second group holds eight synchronization events. Each event sets a sticky raw status bit. A per-event enable vector selects which raw bits count toward the interrupt. Software sees both the raw view and the enabled (masked) view of each group.

Software reaches the block over a simple 32-bit register bus with word addresses. A write is accepted in the cycle where `bus_wr` is high. A read is combinational: `bus_rdata` follows `bus_addr` in the same cycle. Enables have two write-1 ports: one sets bits and the other clears them, and both read back the same vector. Writing 1 to a masked status bit clears the raw bit, and this works even when the event is disabled. Writing 1 to a raw status bit forces the bit on, so test code can inject an event.

Once the interrupt line goes high it stays high until software writes an end-of-interrupt for line 0. If work is still pending at that point, the line goes high again one cycle later.

Top module: `irq_status_ctrl`

## Requirements
- R1: The register map uses word addresses, with byte offsets equal to four times the word address:

  | Word address | Byte offset | Register |
  |---|---|---|
  | 8 | 0x20 | end-of-interrupt |
  | 9 | 0x24 | error raw |
  | 10 | 0x28 | error masked |
  | 11 | 0x2C | error enable-set |
  | 12 | 0x30 | error enable-clear |
  | 13 | 0x34 | sync raw |
  | 14 | 0x38 | sync masked |
  | 15 | 0x3C | sync enable-set |
  | 16 | 0x40 | sync enable-clear |

- R2: A one-cycle event pulse latches its raw bit at the next clock edge, whether or not the event is enabled.
- R3: Writing 1 to a raw status bit sets that bit. Writing 0 to it has no effect.
- R4: A masked status bit reads 1 only when its raw bit and its enable bit are both 1.
- R5: Writing 1 to a masked status bit clears the raw bit, even when that event is disabled.
- R6: Writing 1 to an enable-set bit enables the event. Writing 1 to an enable-clear bit disables it. Zeros are ignored, and both addresses read back the current enable vector.
- R7: The error group uses bit 0 only. The sync group uses bits 7:0. All status and enable bits reset to 0, and bits above a group's field read as 0.
- R8: A write to the end-of-interrupt register with bit 0 = 0 ends the interrupt on line 0. A write with bit 0 = 1 has no effect. The register always reads 0.
- R9: `irq_out` rises one cycle after any masked bit in either group becomes 1. It then stays high until an end-of-interrupt for line 0, even if the pending bits clear.
- R10: In the cycle after an end-of-interrupt, `irq_out` is low. It rises again one cycle later if any masked bit is still 1.
- R11: If a hardware event and a masked-status clear hit the same raw bit in one cycle, the bit stays set.
- R12: Reads of unmapped word addresses return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| err_evt | input | 1 | Clock-error event pulse |
| sync_evt | input | 8 | Synchronization event pulses |
| irq_out | output | 1 | Interrupt line 0 |

## Verification
Register and status effects appear one clock edge after a write or event pulse. The bench drives inputs on the falling edge and reads `bus_rdata` a moment after setting the address in the following low phase. `irq_out` runs one register behind the masked status. The interrupt checks therefore first confirm that the line is still low at the first falling edge after the enabling stimulus, then that it is high at the next one. After an end-of-interrupt write, the line is checked low at the first falling edge and, when work is still pending, high at the second. The cycle in which an event pulse and a clear arrive together is driven as a single stimulus, so the priority between them is tested directly.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  localparam int unsigned DATA_W = 32;

  // word addresses of the register map
  localparam int unsigned OFS_EOI     = 8;
  localparam int unsigned OFS_ERR_RAW = 9;
  localparam int unsigned OFS_ERR_MSK = 10;
  localparam int unsigned OFS_ERR_ENS = 11;
  localparam int unsigned OFS_ERR_ENC = 12;
  localparam int unsigned OFS_SYN_RAW = 13;
  localparam int unsigned OFS_SYN_MSK = 14;
  localparam int unsigned OFS_SYN_ENS = 15;
  localparam int unsigned OFS_SYN_ENC = 16;

  typedef struct packed {
    logic raw_set;
    logic msk_clr;
    logic en_set;
    logic en_clr;
  } grp_we_t;

  // next raw state: a clear loses against a set or an event on the same bit
  function automatic logic [DATA_W-1:0] raw_next(
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] set_bits,
    input logic [DATA_W-1:0] clr_bits,
    input logic [DATA_W-1:0] evt_bits);
    return (cur & ~clr_bits) | set_bits | evt_bits;
  endfunction

  function automatic logic [DATA_W-1:0] en_next(
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] set_bits,
    input logic [DATA_W-1:0] clr_bits);
    return (cur | set_bits) & ~clr_bits;
  endfunction

endpackage

// File: rtl/irq_evt_group.sv
module irq_evt_group
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  grp_we_t      we,
  input  logic [N-1:0] wfield,
  output logic [N-1:0] raw,
  output logic [N-1:0] en,
  output logic [N-1:0] masked
);

  logic [N-1:0] raw_q, en_q;
  logic [N-1:0] set_bits, clr_bits, ens_bits, enc_bits;
  logic [DATA_W-1:0] raw_full, en_full;

  assign set_bits = we.raw_set ? wfield : '0;
  assign clr_bits = we.msk_clr ? wfield : '0;
  assign ens_bits = we.en_set  ? wfield : '0;
  assign enc_bits = we.en_clr  ? wfield : '0;

  assign raw_full = raw_next(DATA_W'(raw_q), DATA_W'(set_bits),
                             DATA_W'(clr_bits), DATA_W'(evt));
  assign en_full  = en_next(DATA_W'(en_q), DATA_W'(ens_bits), DATA_W'(enc_bits));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      en_q  <= '0;
    end else begin
      raw_q <= raw_full[N-1:0];
      en_q  <= en_full[N-1:0];
    end
  end

  assign raw    = raw_q;
  assign en     = en_q;
  assign masked = raw_q & en_q;

  // an event always leaves its raw bit set, whatever else happens that cycle
  assert_evt_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((raw_q & $past(evt)) == $past(evt)));

  assert_msk_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we.msk_clr |=> ((raw_q & $past(wfield & ~evt)) == '0));

  assert_en_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we.en_set |=> ((en_q & $past(wfield)) == $past(wfield)));

  assert_en_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we.en_clr |=> ((en_q & $past(wfield)) == '0));

endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned AW    = 6,
  parameter int unsigned ERR_N = 1,
  parameter int unsigned SYN_N = 8
) (
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic              wbit0,
  input  logic [ERR_N-1:0]  err_raw,
  input  logic [ERR_N-1:0]  err_en,
  input  logic [ERR_N-1:0]  err_msk,
  input  logic [SYN_N-1:0]  syn_raw,
  input  logic [SYN_N-1:0]  syn_en,
  input  logic [SYN_N-1:0]  syn_msk,
  output grp_we_t           err_we,
  output grp_we_t           syn_we,
  output logic              eoi_line0,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [AW-1:0] A_EOI     = AW'(OFS_EOI);
  localparam logic [AW-1:0] A_ERR_RAW = AW'(OFS_ERR_RAW);
  localparam logic [AW-1:0] A_ERR_MSK = AW'(OFS_ERR_MSK);
  localparam logic [AW-1:0] A_ERR_ENS = AW'(OFS_ERR_ENS);
  localparam logic [AW-1:0] A_ERR_ENC = AW'(OFS_ERR_ENC);
  localparam logic [AW-1:0] A_SYN_RAW = AW'(OFS_SYN_RAW);
  localparam logic [AW-1:0] A_SYN_MSK = AW'(OFS_SYN_MSK);
  localparam logic [AW-1:0] A_SYN_ENS = AW'(OFS_SYN_ENS);
  localparam logic [AW-1:0] A_SYN_ENC = AW'(OFS_SYN_ENC);

  always_comb begin
    err_we.raw_set = wr && (addr == A_ERR_RAW);
    err_we.msk_clr = wr && (addr == A_ERR_MSK);
    err_we.en_set  = wr && (addr == A_ERR_ENS);
    err_we.en_clr  = wr && (addr == A_ERR_ENC);
    syn_we.raw_set = wr && (addr == A_SYN_RAW);
    syn_we.msk_clr = wr && (addr == A_SYN_MSK);
    syn_we.en_set  = wr && (addr == A_SYN_ENS);
    syn_we.en_clr  = wr && (addr == A_SYN_ENC);
    eoi_line0      = wr && (addr == A_EOI) && !wbit0;
  end

  always_comb begin
    case (addr)
      A_ERR_RAW:            rdata = DATA_W'(err_raw);
      A_ERR_MSK:            rdata = DATA_W'(err_msk);
      A_ERR_ENS, A_ERR_ENC: rdata = DATA_W'(err_en);
      A_SYN_RAW:            rdata = DATA_W'(syn_raw);
      A_SYN_MSK:            rdata = DATA_W'(syn_msk);
      A_SYN_ENS, A_SYN_ENC: rdata = DATA_W'(syn_en);
      default:              rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_line.sv
module irq_line (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic eoi,
  output logic irq
);

  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq_q <= 1'b0;
    else if (eoi)   irq_q <= 1'b0;
    else if (!irq_q) irq_q <= pending;
  end

  assign irq = irq_q;

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !eoi) |=> irq_q);

  assert_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_q && pending && !eoi) |=> irq_q);

  assert_eoi_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eoi |=> !irq_q);

  assert_rise_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(pending));

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned AW    = 6,
  parameter int unsigned ERR_N = 1,
  parameter int unsigned SYN_N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [ERR_N-1:0]  err_evt,
  input  logic [SYN_N-1:0]  sync_evt,
  output logic              irq_out
);

  grp_we_t          err_we, syn_we;
  logic             eoi_line0;
  logic [ERR_N-1:0] err_raw, err_en, err_msk;
  logic [SYN_N-1:0] syn_raw, syn_en, syn_msk;
  logic             any_pending;

  irq_reg_decode #(.AW(AW), .ERR_N(ERR_N), .SYN_N(SYN_N)) u_dec (
    .wr(bus_wr), .addr(bus_addr), .wbit0(bus_wdata[0]),
    .err_raw(err_raw), .err_en(err_en), .err_msk(err_msk),
    .syn_raw(syn_raw), .syn_en(syn_en), .syn_msk(syn_msk),
    .err_we(err_we), .syn_we(syn_we), .eoi_line0(eoi_line0),
    .rdata(bus_rdata));

  irq_evt_group #(.N(ERR_N)) u_err (
    .clk(clk), .rst_n(rst_n), .evt(err_evt), .we(err_we),
    .wfield(bus_wdata[ERR_N-1:0]),
    .raw(err_raw), .en(err_en), .masked(err_msk));

  irq_evt_group #(.N(SYN_N)) u_syn (
    .clk(clk), .rst_n(rst_n), .evt(sync_evt), .we(syn_we),
    .wfield(bus_wdata[SYN_N-1:0]),
    .raw(syn_raw), .en(syn_en), .masked(syn_msk));

  assign any_pending = (|err_msk) || (|syn_msk);

  irq_line u_line (
    .clk(clk), .rst_n(rst_n), .pending(any_pending),
    .eoi(eoi_line0), .irq(irq_out));

  // an end-of-interrupt with line number 1 never drops the line
  assert_eoi_line1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && bus_wr && bus_addr == AW'(OFS_EOI) && bus_wdata[0]) |=> irq_out);

endmodule

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;

  localparam int AW = 6;
  localparam logic [AW-1:0] EOI = 8, ERAW = 9, EMSK = 10, EENS = 11, EENC = 12,
                            SRAW = 13, SMSK = 14, SENS = 15, SENC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        err_evt = 1'b0;
  logic [7:0]  sync_evt = '0;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_status_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .err_evt(err_evt),
    .sync_evt(sync_evt), .irq_out(irq_out));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic rd_check(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
    bus_addr = '0;
  endtask

  task automatic pulse(input logic e, input logic [7:0] s);
    @(negedge clk);
    err_evt = e; sync_evt = s;
    @(negedge clk);
    err_evt = 1'b0; sync_evt = '0;
  endtask

  task automatic t_reset;
    rd_check("R7 err raw reset", ERAW, 0);
    rd_check("R7 err en reset", EENS, 0);
    rd_check("R7 sync raw reset", SRAW, 0);
    rd_check("R7 sync msk reset", SMSK, 0);
    rd_check("R7 sync en reset", SENC, 0);
    check("R9 irq reset", 32'(irq_out), 0);
  endtask

  task automatic t_disabled_event;
    pulse(1'b0, 8'h04);
    rd_check("R2 raw latches disabled", SRAW, 32'h04);
    rd_check("R4 masked zero when disabled", SMSK, 0);
    @(negedge clk);
    check("R9 no irq when disabled", 32'(irq_out), 0);
  endtask

  task automatic t_raw_force;
    wr(ERAW, 32'h1);
    rd_check("R3 err raw forced", ERAW, 32'h1);
    rd_check("R4 err masked off", EMSK, 0);
    wr(SRAW, 32'h0);
    rd_check("R3 zero write ignored", SRAW, 32'h04);
    wr(SRAW, 32'h1);
    rd_check("R3 sync raw forced", SRAW, 32'h05);
  endtask

  task automatic t_enable_irq;
    wr(SENS, 32'h0C);
    rd_check("R6 set readback", SENS, 32'h0C);
    rd_check("R6 clr readback", SENC, 32'h0C);
    rd_check("R4 masked and", SMSK, 32'h04);
    check("R9 irq one cycle later", 32'(irq_out), 0);
    @(negedge clk);
    check("R9 irq asserted", 32'(irq_out), 1);
  endtask

  task automatic t_clear_hold;
    wr(SMSK, 32'h05);
    rd_check("R5 raw cleared incl disabled", SRAW, 0);
    rd_check("R4 masked cleared", SMSK, 0);
    wr(EMSK, 32'h1);
    rd_check("R5 err raw cleared while disabled", ERAW, 0);
    check("R9 irq held without eoi", 32'(irq_out), 1);
    wr(EOI, 32'h0);
    check("R8 eoi drops line", 32'(irq_out), 0);
    @(negedge clk);
    check("R10 stays low when idle", 32'(irq_out), 0);
  endtask

  task automatic t_eoi_rearm;
    pulse(1'b0, 8'h08);
    @(negedge clk);
    check("R9 irq from bit3", 32'(irq_out), 1);
    wr(EOI, 32'h1);
    check("R8 line1 eoi ignored", 32'(irq_out), 1);
    rd_check("R8 eoi reads zero", EOI, 0);
    wr(EOI, 32'h0);
    check("R10 low after eoi", 32'(irq_out), 0);
    @(negedge clk);
    check("R10 rearms when pending", 32'(irq_out), 1);
  endtask

  task automatic t_enable_clear;
    wr(SENC, 32'h08);
    rd_check("R6 clr disables", SENS, 32'h04);
    rd_check("R4 masked off after disable", SMSK, 0);
    wr(SENS, 32'h0);
    rd_check("R6 zero set ignored", SENC, 32'h04);
    wr(EOI, 32'h0);
    @(negedge clk);
    check("R10 no rearm when nothing enabled pending", 32'(irq_out), 0);
  endtask

  task automatic t_err_group;
    wr(EENS, 32'h1);
    pulse(1'b1, 8'h00);
    rd_check("R2 err raw latched", ERAW, 32'h1);
    rd_check("R4 err masked", EMSK, 32'h1);
    @(negedge clk);
    check("R9 irq from error group", 32'(irq_out), 1);
    wr(EMSK, 32'h1);
    wr(EOI, 32'h0);
    @(negedge clk);
    check("R10 idle after err service", 32'(irq_out), 0);
  endtask

  task automatic t_collision;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = SMSK; bus_wdata = 32'h20; sync_evt = 8'h20;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; sync_evt = '0;
    rd_check("R11 event beats clear", SRAW, 32'h28);
    wr(SMSK, 32'h28);
    rd_check("R5 cleared after collision", SRAW, 0);
  endtask

  task automatic t_unmapped;
    wr(6'd0, 32'hFFFF_FFFF);
    wr(6'd17, 32'hFFFF_FFFF);
    wr(6'd63, 32'hFFFF_FFFF);
    rd_check("R12 unmapped read 0", 6'd0, 0);
    rd_check("R12 unmapped read 17", 6'd17, 0);
    rd_check("R12 unmapped read 63", 6'd63, 0);
    rd_check("R12 sync en untouched", SENS, 32'h04);
    rd_check("R12 err en untouched", EENS, 32'h1);
    rd_check("R1 sync raw untouched", SRAW, 0);
    wr(SRAW, 32'hFFFF_FFFF);
    rd_check("R7 sync field width", SRAW, 32'hFF);
    wr(ERAW, 32'hFFFF_FFFF);
    rd_check("R7 err field width", ERAW, 32'h1);
    rd_check("R1 err masked address", EMSK, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled_event();
    t_raw_force();
    t_enable_irq();
    t_clear_hold();
    t_eoi_rearm();
    t_enable_clear();
    t_err_group();
    t_collision();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule